// File: doc/BRIEF.md
# Staged-Decode Configuration Register Bank

This block holds a large bank of configuration words and exposes every word at once on one wide parallel output, so downstream logic can use any number of them in the same cycle. A configuration master writes it through a narrow port. It presents an address and a data word together with a one-cycle `cfg_valid`. Some cycles later it gives a one-cycle write strobe. There is no read path.

The address is never decoded in one wide cone. It is first captured in a register. Its three fields are then turned into three registered one-hot enables: group, subgroup and entry. A word loads only when its three enable bits and the strobe all agree. The strobe goes through two delay stages so that it meets the enables in the cycle they are valid. Every path is therefore a single-cycle register-to-register path, and no multicycle timing exception is needed.

The port contract is as follows. The strobe is sampled at least 2 cycles after `cfg_valid`. The next `cfg_valid` comes no earlier than 2 cycles after the strobe.

Top module: `cfg_regbank`

## Requirements
- R1: A synchronous active-high `rst` clears every word of `cfg_bank` to zero and forgets any captured address. After a clock edge with `rst` high, `cfg_bank` reads all zero.
- R2: `cfg_addr` and `cfg_data` are captured on the edge where `cfg_valid` is high. A later `cfg_wstb` pulse then stores the captured data into the word at the captured address.
- R3: A write changes only the addressed word. Every other word keeps its value.
- R4: While no strobe arrives, every word holds its value, whatever `cfg_valid`, `cfg_addr` and `cfg_data` do.
- R5: A strobe that arrives when no `cfg_valid` has been seen since reset writes nothing.
- R6: Word n occupies `cfg_bank[32n+31:32n]` at the default parameters. The address field map is fixed:
  - bits [9:8] select the group;
  - bits [7:4] select the subgroup;
  - bits [3:0] select the entry.
- R7: A second write to the same address replaces the first value. The last write wins.
- R8: The stored value appears on `cfg_bank` after the second clock edge that follows the edge sampling the strobe. After the first such edge the old value is still shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Captures address and data on this cycle |
| cfg_addr | input | 10 | Word address (group/subgroup/entry fields) |
| cfg_data | input | 32 | Data word to store |
| cfg_wstb | input | 1 | One-cycle write strobe, issued after `cfg_valid` |
| cfg_bank | output | 32768 | All words, word n at bits [32n+31:32n] |

## Verification
The bench aims at the address corners where the fields roll over, for example 0x0FF to 0x100 and 0x3FF. A swapped or shifted field in the decode would land data in the wrong word, and the whole-bank comparison after each write catches that. It samples the output one edge early to catch a strobe delay that is too short, and the right edge to catch one that is too long. A strobe issued straight after reset, before any address has been presented, exposes decode registers that are not cleared, because such a strobe would write into a stale word. Idle stretches that toggle the address and data with no strobe catch an entry that loads without the strobe.

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
  parameter int GRP_BITS = 2,
  parameter int SUB_BITS = 4,
  parameter int ENT_BITS = 4,
  parameter int DATA_W   = 32
) (
  input  logic                                                  clk,
  input  logic                                                  rst,
  input  logic                                                  cfg_valid,
  input  logic [GRP_BITS+SUB_BITS+ENT_BITS-1:0]                 cfg_addr,
  input  logic [DATA_W-1:0]                                     cfg_data,
  input  logic                                                  cfg_wstb,
  output logic [(1<<(GRP_BITS+SUB_BITS+ENT_BITS))*DATA_W-1:0]   cfg_bank
);
  localparam int ADDR_W = GRP_BITS + SUB_BITS + ENT_BITS;
  localparam int N_GRP  = 1 << GRP_BITS;
  localparam int N_SUB  = 1 << SUB_BITS;
  localparam int N_ENT  = 1 << ENT_BITS;
  localparam int DEPTH  = N_GRP * N_SUB * N_ENT;

  logic              have_addr;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [N_GRP-1:0]  grp_en;
  logic [N_SUB-1:0]  sub_en;
  logic [N_ENT-1:0]  ent_en;
  logic              stb_d1, stb_d2;

  wire [GRP_BITS-1:0] grp_f = addr_q[ADDR_W-1 -: GRP_BITS];
  wire [SUB_BITS-1:0] sub_f = addr_q[ENT_BITS +: SUB_BITS];
  wire [ENT_BITS-1:0] ent_f = addr_q[0 +: ENT_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      have_addr <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      grp_en    <= '0;
      sub_en    <= '0;
      ent_en    <= '0;
      stb_d1    <= 1'b0;
      stb_d2    <= 1'b0;
    end else begin
      if (cfg_valid) begin
        have_addr <= 1'b1;
        addr_q    <= cfg_addr;
        data_q    <= cfg_data;
      end
      grp_en <= have_addr ? ({{(N_GRP-1){1'b0}}, 1'b1} << grp_f) : '0;
      sub_en <= have_addr ? ({{(N_SUB-1){1'b0}}, 1'b1} << sub_f) : '0;
      ent_en <= have_addr ? ({{(N_ENT-1){1'b0}}, 1'b1} << ent_f) : '0;
      stb_d1 <= cfg_wstb;
      stb_d2 <= stb_d1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam int GI = i / (N_SUB * N_ENT);
    localparam int SI = (i / N_ENT) % N_SUB;
    localparam int EI = i % N_ENT;
    logic [DATA_W-1:0] val_q;
    wire ld = stb_d2 & grp_en[GI] & sub_en[SI] & ent_en[EI];
    always_ff @(posedge clk) begin
      if (rst)     val_q <= '0;
      else if (ld) val_q <= data_q;
    end
    assign cfg_bank[i*DATA_W +: DATA_W] = val_q;
  end

  logic [ADDR_W-1:0] dec_idx_q;
  always_ff @(posedge clk) begin
    if (rst) dec_idx_q <= '0;
    else     dec_idx_q <= addr_q;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> cfg_bank == '0);

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (stb_d2 && (|grp_en)) |=> cfg_bank[$past(dec_idx_q)*DATA_W +: DATA_W] == $past(data_q));

  assert_hold_no_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    !stb_d2 |=> $stable(cfg_bank));

  assert_no_addr_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    !have_addr |=> $stable(cfg_bank));
endmodule

// File: tb/cfg_regbank_tb_top.sv
module cfg_regbank_tb_top;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_valid = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_data = '0;
  logic cfg_wstb = 1'b0;
  logic [DEPTH*DW-1:0] cfg_bank;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] ref_mem [DEPTH];

  always #10 clk = ~clk;

  cfg_regbank dut_i (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cfg_wstb(cfg_wstb), .cfg_bank(cfg_bank)
  );

  function automatic logic [DW-1:0] word_at(int n);
    return cfg_bank[n*DW +: DW];
  endfunction

  function automatic int bank_diffs();
    int d = 0;
    for (int n = 0; n < DEPTH; n++) if (word_at(n) != ref_mem[n]) d++;
    return d;
  endfunction

  task automatic check_bank(string req);
    int d = bank_diffs();
    checks++;
    if (d != 0) begin
      errors++;
      $display("FAIL %s: %0d words differ from model, expected 0", req, d);
    end
  endtask

  task automatic check_word(string req, int n, logic [DW-1:0] exp);
    checks++;
    if (word_at(n) !== exp) begin
      errors++;
      $display("FAIL %s: word %0d = %h expected %h", req, n, word_at(n), exp);
    end
  endtask

  task automatic clear_model();
    for (int n = 0; n < DEPTH; n++) ref_mem[n] = '0;
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, int lag);
    logic [DW-1:0] old = ref_mem[a];
    @(negedge clk);
    cfg_valid = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_valid = 1'b0;
    repeat (lag - 1) @(negedge clk);
    cfg_wstb = 1'b1;
    @(negedge clk);
    cfg_wstb = 1'b0;
    @(negedge clk);
    check_word("R8", a, old);
    @(negedge clk);
    ref_mem[a] = d;
    check_word("R2", a, d);
    check_bank("R3");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    clear_model();
    check_bank("R1");
  endtask

  task automatic lone_strobe();
    @(negedge clk);
    cfg_wstb = 1'b1;
    @(negedge clk);
    cfg_wstb = 1'b0;
    repeat (4) @(negedge clk);
    check_bank("R5");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_bank("R1");

    cfg_addr = 10'h155; cfg_data = 32'hDEADBEEF;
    lone_strobe();

    do_write(10'h000, 32'h1111_0000, 2);
    do_write(10'h3FF, 32'hFFFF_0001, 2);
    do_write(10'h0FF, 32'h0F0F_00FF, 3);
    do_write(10'h100, 32'h0100_0100, 2);
    do_write(10'h0F0, 32'hF0F0_0010, 4);
    do_write(10'h010, 32'h0010_0010, 2);
    check_word("R6", 1023, 32'hFFFF_0001);
    check_word("R6", 256, 32'h0100_0100);
    check_word("R6", 255, 32'h0F0F_00FF);

    do_write(10'h2A5, 32'hAAAA_5555, 2);
    do_write(10'h2A5, 32'h5555_AAAA, 3);
    check_word("R7", 10'h2A5, 32'h5555_AAAA);

    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cfg_valid = (k % 3 == 0);
      cfg_addr = AW'($urandom);
      cfg_data = $urandom;
    end
    @(negedge clk);
    cfg_valid = 1'b0;
    check_bank("R4");

    for (int k = 0; k < 150; k++)
      do_write(AW'($urandom), $urandom, 2 + int'($urandom % 4));

    do_reset();
    cfg_addr = 10'h2A5; cfg_data = 32'h1234_5678;
    lone_strobe();
    do_write(10'h2A5, 32'hCAFE_F00D, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule